// File: doc/BRIEF.md
# Prescaled Pulse Width Modulator

This block generates one or two pulse-width-modulated outputs. Each channel owns three 32-bit registers on a word-addressed write/read bus: a control word (prescale value and a shutdown-style bit), a duty word (high-count and a force-high flag) and a period word. The input clock first passes through a divide-by-(prescale+1) stage. That stage produces a counting tick. A 10-bit period counter advances on each tick. The output is high at the start of each period for the programmed number of ticks.

Each channel has an enable input that stands in for its gated functional clock. When a channel is enabled it starts a fresh period. Values written while the channel runs are held until the next period boundary, so the running waveform never shows a cut or mixed period. When the enable drops, the control word decides what happens. The channel either stops at once and forces its output low, or it completes the period it is in and goes low at the boundary.

Top module: `pwm_prescaled`

## Requirements
- R1: A synchronous active-low reset clears every register to zero and holds every output low.
- R2: Byte offset 0x00 holds the control word, 0x04 the duty word and 0x08 the period word of channel 0. Channel 1 repeats them at 0x10, 0x14 and 0x18. Reads return the last written value with unused bits as zero. Control keeps bits [6:0], duty keeps bits [10:0] and period keeps bits [9:0]. Any other offset, and any channel that is not built, reads as zero.
- R3: The prescale field, control bits [5:0] (0 to 63), divides the clock by prescale+1. One period lasts (prescale+1)*(PV+1) clocks, where PV is period bits [9:0].
- R4: The output is high for the first DC ticks of each period and low for the rest, where DC is duty bits [9:0].
- R5: When duty bit 10 is set, the output stays high for the entire period whatever DC holds.
- R6: When DC is 0 and bit 10 is clear, the output stays low. When DC is PV+1 or larger, the output stays high for the whole period.
- R7: When control bit 6 is set and the enable is low, the output is low in that same cycle and the count stops. A later enable starts a fresh period.
- R8: When control bit 6 is clear and the enable drops, the current period completes with its normal waveform. The output goes low at the period boundary.
- R9: Prescale, DC, PV and the force-high flag written while a channel runs take effect at the next period boundary.
- R10: The first period begins in the clock after the enable is sampled high. Until then, and while the channel is stopped, the output is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock |
| rst_n | input | 1 | Synchronous reset, active low |
| bus_wr | input | 1 | Write strobe |
| bus_addr | input | 5 | Byte address; bits [1:0] ignored |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| chan_en | input | NUM_CH | Per-channel enable |
| pwm_out | output | NUM_CH | Per-channel PWM output |

## Verification
A prescale or period counter that is off by one shows up at the output within one period. The high time or the period length then differs from the arithmetic value, so the per-cycle comparison across a sweep of prescale, PV and DC combinations catches it. A shadow copy that is loaded at the wrong moment shows up as a wrong waveform in the period right after a mid-run write. A run flag that is cleared or kept wrongly shows up in the cycle the enable drops, or at the next period boundary.

// File: rtl/pwm_pkg.sv
package pwm_pkg;
  parameter int PRE_W  = 6;
  parameter int CNT_W  = 10;
  parameter int DATA_W = 32;
  parameter int ADDR_W = 5;
  localparam int ABRUPT_BIT = PRE_W;
  localparam int FULL_BIT   = CNT_W;

  typedef struct packed {
    logic [PRE_W-1:0] pre;
    logic             abrupt;
    logic [CNT_W-1:0] dc;
    logic             full;
    logic [CNT_W-1:0] pv;
  } ch_cfg_t;

  typedef enum logic [1:0] {SEL_CTRL = 2'd0, SEL_DUTY = 2'd1, SEL_PER = 2'd2, SEL_NONE = 2'd3} reg_sel_e;

  function automatic logic duty_on(input logic [CNT_W-1:0] cnt,
                                   input logic [CNT_W-1:0] dc,
                                   input logic full);
    return full || (cnt < dc);
  endfunction

  function automatic logic [DATA_W-1:0] pack_ctrl(input ch_cfg_t c);
    logic [DATA_W-1:0] w;
    w = '0;
    w[PRE_W-1:0] = c.pre;
    w[ABRUPT_BIT] = c.abrupt;
    return w;
  endfunction

  function automatic logic [DATA_W-1:0] pack_duty(input ch_cfg_t c);
    logic [DATA_W-1:0] w;
    w = '0;
    w[CNT_W-1:0] = c.dc;
    w[FULL_BIT] = c.full;
    return w;
  endfunction

  function automatic logic [DATA_W-1:0] pack_per(input ch_cfg_t c);
    logic [DATA_W-1:0] w;
    w = '0;
    w[CNT_W-1:0] = c.pv;
    return w;
  endfunction
endpackage

// File: rtl/pwm_regs.sv
module pwm_regs
  import pwm_pkg::*;
#(
  parameter int NUM_CH = 2
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     wr,
  input  logic [ADDR_W-1:0]        addr,
  input  logic [DATA_W-1:0]        wdata,
  output logic [DATA_W-1:0]        rdata,
  output ch_cfg_t [NUM_CH-1:0]     cfg
);
  localparam int CH_SEL_W = ADDR_W - 4;

  logic [CH_SEL_W-1:0] ch_idx;
  reg_sel_e            sel;
  logic                unused_bits;

  assign ch_idx = addr[ADDR_W-1:4];
  assign sel    = reg_sel_e'(addr[3:2]);
  assign unused_bits = &{1'b0, addr[1:0], wdata[DATA_W-1:FULL_BIT+1]};

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    logic hit;
    assign hit = wr && (ch_idx == CH_SEL_W'(c));
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        cfg[c] <= '0;
      end else if (hit) begin
        case (sel)
          SEL_CTRL: begin
            cfg[c].pre    <= wdata[PRE_W-1:0];
            cfg[c].abrupt <= wdata[ABRUPT_BIT];
          end
          SEL_DUTY: begin
            cfg[c].dc   <= wdata[CNT_W-1:0];
            cfg[c].full <= wdata[FULL_BIT];
          end
          SEL_PER: cfg[c].pv <= wdata[CNT_W-1:0];
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    rdata = '0;
    for (int c = 0; c < NUM_CH; c++) begin
      if (ch_idx == CH_SEL_W'(c)) begin
        case (sel)
          SEL_CTRL: rdata = pack_ctrl(cfg[c]);
          SEL_DUTY: rdata = pack_duty(cfg[c]);
          SEL_PER:  rdata = pack_per(cfg[c]);
          default:  rdata = '0;
        endcase
      end
    end
  end
endmodule

// File: rtl/pwm_chan.sv
module pwm_chan
  import pwm_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    en,
  input  ch_cfg_t cfg,
  output logic    out,
  output logic    run_o,
  output logic    tick_o,
  output logic    pend_o
);
  logic             run;
  logic [PRE_W-1:0] pre_cnt;
  logic [CNT_W-1:0] cnt;
  logic [PRE_W-1:0] a_pre;
  logic [CNT_W-1:0] a_dc;
  logic [CNT_W-1:0] a_pv;
  logic             a_full;
  logic             tick;
  logic             pend;
  logic             kill;

  assign tick = run && (pre_cnt == a_pre);
  assign pend = tick && (cnt == a_pv);
  assign kill = run && cfg.abrupt && !en;
  assign out  = run && !kill && duty_on(cnt, a_dc, a_full);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run     <= 1'b0;
      pre_cnt <= '0;
      cnt     <= '0;
      a_pre   <= '0;
      a_dc    <= '0;
      a_pv    <= '0;
      a_full  <= 1'b0;
    end else if (!run) begin
      pre_cnt <= '0;
      cnt     <= '0;
      if (en) begin
        run    <= 1'b1;
        a_pre  <= cfg.pre;
        a_dc   <= cfg.dc;
        a_pv   <= cfg.pv;
        a_full <= cfg.full;
      end
    end else if (kill) begin
      run     <= 1'b0;
      pre_cnt <= '0;
      cnt     <= '0;
    end else if (tick) begin
      pre_cnt <= '0;
      if (pend) begin
        cnt    <= '0;
        a_pre  <= cfg.pre;
        a_dc   <= cfg.dc;
        a_pv   <= cfg.pv;
        a_full <= cfg.full;
        if (!en) run <= 1'b0;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end else begin
      pre_cnt <= pre_cnt + 1'b1;
    end
  end

  assign run_o  = run;
  assign tick_o = tick;
  assign pend_o = pend;
endmodule

// File: rtl/pwm_prescaled.sv
module pwm_prescaled
  import pwm_pkg::*;
#(
  parameter int NUM_CH = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [4:0]        bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic [NUM_CH-1:0] chan_en,
  output logic [NUM_CH-1:0] pwm_out
);
  ch_cfg_t [NUM_CH-1:0] cfg;
  logic [NUM_CH-1:0]    chan_run;
  logic [NUM_CH-1:0]    chan_tick;
  logic [NUM_CH-1:0]    chan_pend;
  logic [NUM_CH-1:0]    chan_abrupt;

  pwm_regs #(.NUM_CH(NUM_CH)) u_regs (
    .clk   (clk),
    .rst_n (rst_n),
    .wr    (bus_wr),
    .addr  (bus_addr),
    .wdata (bus_wdata),
    .rdata (bus_rdata),
    .cfg   (cfg)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_chan
    assign chan_abrupt[c] = cfg[c].abrupt;
    pwm_chan u_chan (
      .clk    (clk),
      .rst_n  (rst_n),
      .en     (chan_en[c]),
      .cfg    (cfg[c]),
      .out    (pwm_out[c]),
      .run_o  (chan_run[c]),
      .tick_o (chan_tick[c]),
      .pend_o (chan_pend[c])
    );
  end
endmodule

// File: rtl/pwm_prescaled_chk.sv
module pwm_prescaled_chk #(
  parameter int NUM_CH = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic [NUM_CH-1:0] chan_en,
  input logic [NUM_CH-1:0] pwm_out,
  input logic [NUM_CH-1:0] chan_run,
  input logic [NUM_CH-1:0] chan_pend,
  input logic [NUM_CH-1:0] chan_abrupt
);
  assert_reset_quiet_R1: assert property (@(posedge clk)
    !rst_n |=> (pwm_out == '0));

  for (genvar c = 0; c < NUM_CH; c++) begin : g_p
    assert_abrupt_low_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (chan_abrupt[c] && !chan_en[c]) |-> !pwm_out[c]);
    assert_abrupt_stop_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (chan_run[c] && chan_abrupt[c] && !chan_en[c]) |=> !chan_run[c]);
    assert_graceful_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (chan_run[c] && !chan_pend[c] && !(chan_abrupt[c] && !chan_en[c])) |=> chan_run[c]);
    assert_stop_reason_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(chan_run[c]) |-> ($past(chan_pend[c]) || $past(chan_abrupt[c])));
    assert_keep_running_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (chan_pend[c] && chan_en[c]) |=> chan_run[c]);
    assert_start_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (!chan_run[c] && chan_en[c]) |=> chan_run[c]);
  end
endmodule

bind pwm_prescaled pwm_prescaled_chk #(.NUM_CH(NUM_CH)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .chan_en     (chan_en),
  .pwm_out     (pwm_out),
  .chan_run    (chan_run),
  .chan_pend   (chan_pend),
  .chan_abrupt (chan_abrupt)
);

// File: tb/test_pwm_prescaled.sv
`timescale 1ns/1ps
module test_pwm_prescaled;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0;
  logic [4:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [1:0]  chan_en = '0;
  logic [1:0]  pwm_out;
  int n_run = 0;
  int n_fail = 0;
  bit done = 0;

  always #2 clk = ~clk;

  pwm_prescaled #(.NUM_CH(2)) i_pwm_prescaled (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .chan_en(chan_en), .pwm_out(pwm_out)
  );

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [4:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  function automatic bit exp_out(input int k, input int pre, input int pv, input int dc, input bit full);
    int p;
    p = (pre + 1) * (pv + 1);
    return full || (((k % p) / (pre + 1)) < dc);
  endfunction

  // R3 R4 R5 R6 R10: program, enable, compare every cycle of two periods
  task automatic run_check(input int ch, input int pre, input int pv, input int dc, input bit full, input string req);
    int errs, first_k, p;
    logic [4:0] base;
    base = 5'(ch * 16);
    bus_write(base + 5'h00, 32'h40 | pre);
    bus_write(base + 5'h04, (32'(full) << 10) | dc);
    bus_write(base + 5'h08, pv);
    @(negedge clk);
    chan_en[ch] = 1'b1;
    #1 check(pwm_out[ch] == 1'b0, "R10", pwm_out[ch], 0);
    p = (pre + 1) * (pv + 1);
    errs = 0; first_k = -1;
    for (int k = 0; k < 2 * p + 3; k++) begin
      @(negedge clk); #1;
      if (pwm_out[ch] !== exp_out(k, pre, pv, dc, full)) begin
        errs++;
        if (first_k < 0) first_k = k;
      end
    end
    check(errs == 0, req, first_k, -1);
    chan_en[ch] = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++;
      n_run++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    int pvs[3];
    int errs;
    pvs = '{0, 1, 4};
    repeat (3) @(negedge clk);
    // R1: reset state
    check(pwm_out == 2'b00, "R1 out", pwm_out, 0);
    rst_n = 1'b1;
    for (int a = 0; a < 32; a += 4) begin
      bus_read(5'(a), d);
      check(d == 0, "R1 reg", d, 0);
    end
    // R2: readback masks and map
    bus_write(5'h00, 32'hFFFF_FFFF);
    bus_write(5'h04, 32'hFFFF_FFFF);
    bus_write(5'h08, 32'hFFFF_FFFF);
    bus_write(5'h0C, 32'hFFFF_FFFF);
    bus_read(5'h00, d); check(d == 32'h7F,  "R2 ctrl", d, 32'h7F);
    bus_read(5'h04, d); check(d == 32'h7FF, "R2 duty", d, 32'h7FF);
    bus_read(5'h08, d); check(d == 32'h3FF, "R2 per",  d, 32'h3FF);
    bus_read(5'h0C, d); check(d == 0,       "R2 hole", d, 0);
    bus_read(5'h10, d); check(d == 0,       "R2 ch1 untouched", d, 0);
    bus_write(5'h14, 32'h0000_0123);
    bus_read(5'h14, d); check(d == 32'h123, "R2 ch1 duty", d, 32'h123);
    bus_read(5'h04, d); check(d == 32'h7FF, "R2 ch0 kept", d, 32'h7FF);
    check(pwm_out == 2'b00, "R10 idle", pwm_out, 0);
    // sweep
    for (int pre = 0; pre < 3; pre += 2) begin
      foreach (pvs[i]) begin
        run_check(0, pre, pvs[i], 0, 0, "R6 dc0");
        run_check(0, pre, pvs[i], 1, 0, "R4 dc1");
        run_check(0, pre, pvs[i], pvs[i], 0, "R3 dc=pv");
        run_check(0, pre, pvs[i], pvs[i] + 1, 0, "R6 dc=pv+1");
        run_check(0, pre, pvs[i], pvs[i] + 5, 0, "R6 dc>pv+1");
      end
    end
    run_check(0, 1, 3, 0, 1, "R5 full dc0");
    run_check(1, 3, 2, 1, 1, "R5 full ch1");
    run_check(1, 1, 5, 3, 0, "R4 ch1");
    run_check(1, 0, 7, 5, 0, "R3 ch1");

    // R8: graceful stop, pre=1 pv=3 dc=2 -> P=8
    bus_write(5'h00, 32'h01);
    bus_write(5'h04, 32'h02);
    bus_write(5'h08, 32'h03);
    @(negedge clk); chan_en[0] = 1'b1;
    errs = 0;
    for (int k = 0; k < 13; k++) begin
      @(negedge clk); #1;
      if (pwm_out[0] !== ((k < 8) ? exp_out(k, 1, 3, 2, 0) : 1'b0)) errs++;
      if (k == 2) chan_en[0] = 1'b0;
    end
    check(errs == 0, "R8 graceful", errs, 0);

    // R7: abrupt stop and fresh restart
    bus_write(5'h00, 32'h41);
    @(negedge clk); chan_en[0] = 1'b1;
    errs = 0;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk); #1;
      if (pwm_out[0] !== exp_out(k, 1, 3, 2, 0)) errs++;
    end
    chan_en[0] = 1'b0;
    #1 check(pwm_out[0] == 1'b0, "R7 same cycle", pwm_out[0], 0);
    for (int k = 0; k < 6; k++) begin
      @(negedge clk); #1;
      if (pwm_out[0] !== 1'b0) errs++;
    end
    chan_en[0] = 1'b1;
    for (int k = 0; k < 16; k++) begin
      @(negedge clk); #1;
      if (pwm_out[0] !== exp_out(k, 1, 3, 2, 0)) errs++;
    end
    check(errs == 0, "R7 abrupt", errs, 0);
    chan_en[0] = 1'b0;
    @(negedge clk);

    // R9: mid-run update, pre=0 pv=3 dc=2 then pv=5 dc=4 at boundary k=4
    bus_write(5'h00, 32'h40);
    bus_write(5'h04, 32'h02);
    bus_write(5'h08, 32'h03);
    @(negedge clk); chan_en[0] = 1'b1;
    errs = 0;
    for (int k = 0; k < 16; k++) begin
      @(negedge clk); #1;
      if (pwm_out[0] !== ((k < 4) ? (k < 2) : (((k - 4) % 6) < 4))) errs++;
      if (k == 1) begin bus_wr = 1'b1; bus_addr = 5'h08; bus_wdata = 32'd5; end
      if (k == 2) begin bus_addr = 5'h04; bus_wdata = 32'd4; end
      if (k == 3) bus_wr = 1'b0;
    end
    check(errs == 0, "R9 boundary update", errs, 0);
    chan_en[0] = 1'b0;
    @(negedge clk); #1;
    check(pwm_out[0] == 1'b0, "R7 stopped", pwm_out[0], 0);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule